// File: doc/BRIEF.md
# Confidence-Gated Last-Value Predictor

This block predicts the result of an instruction from the result the same static instruction produced last time. Two tables are indexed directly by bits of the instruction address. The value table keeps one result word and a valid flag per slot. The smaller confidence table keeps a two-bit saturating counter per slot. The front end presents an address on the query port. In the same cycle it gets back the remembered word and a flag that says whether the word is trustworthy enough to forward to dependent instructions.

When the instruction has executed, the back end presents the same address and the true result on the training port. The block compares the true result with the remembered word. It then moves the counter one step up or down. It overwrites the word only if the counter was below its top state. So a slot that has earned full confidence survives a single stray result. Recovery and reissue of wrongly fed instructions are handled elsewhere.

Top module: `lastval_predictor`

## Requirements
- R1: After a synchronous reset every valid flag is clear and every counter is 0, so `q_use` is 0 for any query address until a training write arrives.
- R2: Training an address whose value slot is invalid stores `t_result`, marks the slot valid and sets the shared counter to 0. A following query returns that word with `q_use` = 0.
- R3: Training a valid slot with a result equal to the stored word raises the counter by one, stopping at 3, and leaves the word unchanged.
- R4: Training a valid slot with a different result lowers the counter by one, stopping at 0.
- R5: On a mismatch with the counter at 0, 1 or 2 beforehand, the stored word is replaced by `t_result`.
- R6: On a mismatch with the counter at 3 beforehand, the stored word is kept. The counter drops to 2, so the prediction is still offered.
- R7: `q_use` is 1 exactly when the queried value slot is valid and its counter is 2 or 3. A slot with counter 0 or 1 gives `q_use` = 0.
- R8: The query port is combinational. A training write takes effect at the next rising clock edge. A query to the same slot in the same cycle as the write returns the contents from before the write.
- R9: The value slot is selected by `pc[VAL_IDX_W+1:2]` and the counter by `pc[CONF_IDX_W+1:2]`. Address bits 1:0 are ignored. Addresses that differ only above the counter field share one counter.
- R10: While `t_en` is 0, the training inputs change neither table.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous reset, active high |
| q_pc | input | PC_W | Query instruction address |
| q_value | output | XLEN | Remembered result for the queried slot |
| q_use | output | 1 | Prediction may be used |
| t_en | input | 1 | Training write strobe |
| t_pc | input | PC_W | Training instruction address |
| t_result | input | XLEN | Actual computed result |

## Verification
The bench builds the block with 64 value slots, 16 counter slots and a 16-bit address, keeping the full 64-bit result width. With these sizes the index fields are short. Random addresses from a narrow window therefore collide often. Addresses that share a counter but own separate value slots come up constantly. This puts the install-resets-shared-counter case and the lock-after-three-hits case within reach many times per run. The small result alphabet makes matches frequent enough that every counter state, including both saturation ends, is visited.

// File: rtl/lvp_pkg.sv
package lvp_pkg;

    typedef enum logic [1:0] {
        CONF_NONE = 2'd0,
        CONF_WEAK = 2'd1,
        CONF_FIRM = 2'd2,
        CONF_LOCK = 2'd3
    } conf_e;

    function automatic conf_e conf_up(conf_e c);
        return (c == CONF_LOCK) ? CONF_LOCK : conf_e'(c + 2'd1);
    endfunction

    function automatic conf_e conf_down(conf_e c);
        return (c == CONF_NONE) ? CONF_NONE : conf_e'(c - 2'd1);
    endfunction

    function automatic logic conf_trusted(conf_e c);
        return c[1];
    endfunction

endpackage

// File: rtl/lvp_index.sv
module lvp_index #(
    parameter int PC_W       = 32,
    parameter int VAL_IDX_W  = 12,
    parameter int CONF_IDX_W = 10
) (
    input  logic [PC_W-1:0]       pc,
    output logic [VAL_IDX_W-1:0]  val_idx,
    output logic [CONF_IDX_W-1:0] conf_idx
);
    // word-aligned addresses: bits 1:0 carry no information
    localparam int LSB = 2;

    assign val_idx  = pc[LSB+VAL_IDX_W-1:LSB];
    assign conf_idx = pc[LSB+CONF_IDX_W-1:LSB];
endmodule

// File: rtl/lvp_train.sv
module lvp_train
    import lvp_pkg::*;
#(
    parameter int XLEN = 64
) (
    input  logic            en,
    input  logic            old_vld,
    input  logic [XLEN-1:0] old_val,
    input  conf_e           old_conf,
    input  logic [XLEN-1:0] result,
    output logic            val_we,
    output logic [XLEN-1:0] val_wdata,
    output logic            conf_we,
    output conf_e           conf_wdata
);
    always_comb begin
        val_we     = 1'b0;
        val_wdata  = result;
        conf_we    = 1'b0;
        conf_wdata = old_conf;
        if (en) begin
            conf_we = 1'b1;
            if (!old_vld) begin
                val_we     = 1'b1;
                conf_wdata = CONF_NONE;
            end else if (old_val == result) begin
                conf_wdata = conf_up(old_conf);
            end else begin
                conf_wdata = conf_down(old_conf);
                val_we     = (old_conf != CONF_LOCK);
            end
        end
    end
endmodule

// File: rtl/lastval_predictor.sv
module lastval_predictor
    import lvp_pkg::*;
#(
    parameter int XLEN         = 64,
    parameter int PC_W         = 32,
    parameter int VAL_ENTRIES  = 4096,
    parameter int CONF_ENTRIES = 1024
) (
    input  logic            clk,
    input  logic            rst,
    input  logic [PC_W-1:0] q_pc,
    output logic [XLEN-1:0] q_value,
    output logic            q_use,
    input  logic            t_en,
    input  logic [PC_W-1:0] t_pc,
    input  logic [XLEN-1:0] t_result
);
    localparam int VAL_IDX_W  = $clog2(VAL_ENTRIES);
    localparam int CONF_IDX_W = $clog2(CONF_ENTRIES);

    typedef struct packed {
        logic            val_we;
        logic [XLEN-1:0] val_data;
        logic            conf_we;
        conf_e           conf_data;
    } wr_t;

    logic [XLEN-1:0]  val_q  [VAL_ENTRIES];
    logic [VAL_ENTRIES-1:0] vld_q;
    conf_e            conf_q [CONF_ENTRIES];

    logic [VAL_IDX_W-1:0]  q_vidx,  t_vidx;
    logic [CONF_IDX_W-1:0] q_cidx,  t_cidx;

    lvp_index #(.PC_W(PC_W), .VAL_IDX_W(VAL_IDX_W), .CONF_IDX_W(CONF_IDX_W)) u_q_idx (
        .pc(q_pc), .val_idx(q_vidx), .conf_idx(q_cidx)
    );
    lvp_index #(.PC_W(PC_W), .VAL_IDX_W(VAL_IDX_W), .CONF_IDX_W(CONF_IDX_W)) u_t_idx (
        .pc(t_pc), .val_idx(t_vidx), .conf_idx(t_cidx)
    );

    // query port: pure read of current state
    assign q_value = val_q[q_vidx];
    assign q_use   = vld_q[q_vidx] && conf_trusted(conf_q[q_cidx]);

    // training port: read old contents, decide the write
    logic            t_old_vld;
    logic [XLEN-1:0] t_old_val;
    conf_e           t_old_conf;
    assign t_old_vld  = vld_q[t_vidx];
    assign t_old_val  = val_q[t_vidx];
    assign t_old_conf = conf_q[t_cidx];

    logic            tr_val_we, tr_conf_we;
    logic [XLEN-1:0] tr_val_data;
    conf_e           tr_conf_data;

    lvp_train #(.XLEN(XLEN)) u_train (
        .en(t_en), .old_vld(t_old_vld), .old_val(t_old_val), .old_conf(t_old_conf),
        .result(t_result), .val_we(tr_val_we), .val_wdata(tr_val_data),
        .conf_we(tr_conf_we), .conf_wdata(tr_conf_data)
    );

    wr_t wr_d;

    always_comb begin
        wr_d.val_we    = tr_val_we;
        wr_d.val_data  = tr_val_data;
        wr_d.conf_we   = tr_conf_we;
        wr_d.conf_data = tr_conf_data;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            vld_q <= '0;
            for (int i = 0; i < CONF_ENTRIES; i++) conf_q[i] <= CONF_NONE;
        end else begin
            if (wr_d.val_we) begin
                val_q[t_vidx] <= wr_d.val_data;
                vld_q[t_vidx] <= 1'b1;
            end
            if (wr_d.conf_we) conf_q[t_cidx] <= wr_d.conf_data;
        end
    end
endmodule

// File: rtl/lvp_checker.sv
module lvp_checker
    import lvp_pkg::*;
#(
    parameter int XLEN         = 64,
    parameter int VAL_ENTRIES  = 4096,
    parameter int CONF_ENTRIES = 1024,
    parameter int VAL_IDX_W    = 12,
    parameter int CONF_IDX_W   = 10
) (
    input logic                  clk,
    input logic                  rst,
    input logic                  q_use,
    input logic                  t_en,
    input logic [XLEN-1:0]       t_result,
    input logic [VAL_IDX_W-1:0]  t_vidx,
    input logic [CONF_IDX_W-1:0] t_cidx,
    input logic                  t_old_vld,
    input logic [XLEN-1:0]       t_old_val,
    input conf_e                 t_old_conf,
    input logic [VAL_ENTRIES-1:0] vld_tbl,
    input logic [XLEN-1:0]       val_tbl [VAL_ENTRIES],
    input conf_e                 conf_tbl [CONF_ENTRIES]
);
    logic trained;
    logic hit;
    assign trained = t_en && t_old_vld;
    assign hit     = (t_old_val == t_result);

    AST_RESET_NO_USE: assert property (@(posedge clk) disable iff (rst)
        $fell(rst) |-> !q_use);  // R1

    AST_INSTALL_FRESH: assert property (@(posedge clk) disable iff (rst)
        (!$past(rst) && $past(t_en) && !$past(t_old_vld)) |->
        (vld_tbl[$past(t_vidx)] && val_tbl[$past(t_vidx)] == $past(t_result)
         && conf_tbl[$past(t_cidx)] == CONF_NONE));  // R2

    AST_HIT_RAISES: assert property (@(posedge clk) disable iff (rst)
        (!$past(rst) && $past(trained) && $past(hit)) |->
        (2'(conf_tbl[$past(t_cidx)]) ==
         (($past(t_old_conf) == CONF_LOCK) ? 2'd3 : 2'($past(t_old_conf)) + 2'd1)));  // R3

    AST_MISS_FLOOR: assert property (@(posedge clk) disable iff (rst)
        (!$past(rst) && $past(trained) && !$past(hit) && $past(t_old_conf) == CONF_NONE) |->
        (conf_tbl[$past(t_cidx)] == CONF_NONE));  // R4

    AST_MISS_REPLACE: assert property (@(posedge clk) disable iff (rst)
        (!$past(rst) && $past(trained) && !$past(hit) && $past(t_old_conf) != CONF_LOCK) |->
        (val_tbl[$past(t_vidx)] == $past(t_result)));  // R5

    AST_LOCK_KEEPS: assert property (@(posedge clk) disable iff (rst)
        (!$past(rst) && $past(trained) && !$past(hit) && $past(t_old_conf) == CONF_LOCK) |->
        (val_tbl[$past(t_vidx)] == $past(t_old_val) && conf_tbl[$past(t_cidx)] == CONF_FIRM));  // R6
endmodule

bind lastval_predictor lvp_checker #(
    .XLEN(XLEN), .VAL_ENTRIES(VAL_ENTRIES), .CONF_ENTRIES(CONF_ENTRIES),
    .VAL_IDX_W(VAL_IDX_W), .CONF_IDX_W(CONF_IDX_W)
) u_chk (
    .clk(clk), .rst(rst), .q_use(q_use), .t_en(t_en), .t_result(t_result),
    .t_vidx(t_vidx), .t_cidx(t_cidx), .t_old_vld(t_old_vld), .t_old_val(t_old_val),
    .t_old_conf(t_old_conf), .vld_tbl(vld_q), .val_tbl(val_q), .conf_tbl(conf_q)
);

// File: tb/lastval_predictor_test.sv
module lastval_predictor_test;
    localparam int XLEN = 64;
    localparam int PC_W = 16;
    localparam int VE   = 64;
    localparam int CE   = 16;
    localparam int VW   = $clog2(VE);
    localparam int CW   = $clog2(CE);

    logic            clk = 1'b0;
    logic            rst = 1'b1;
    logic [PC_W-1:0] q_pc = '0;
    logic [XLEN-1:0] q_value;
    logic            q_use;
    logic            t_en = 1'b0;
    logic [PC_W-1:0] t_pc = '0;
    logic [XLEN-1:0] t_result = '0;

    lastval_predictor #(.XLEN(XLEN), .PC_W(PC_W), .VAL_ENTRIES(VE), .CONF_ENTRIES(CE)) uut (
        .clk(clk), .rst(rst), .q_pc(q_pc), .q_value(q_value), .q_use(q_use),
        .t_en(t_en), .t_pc(t_pc), .t_result(t_result)
    );

    always #10 clk = ~clk;  // 50 MHz

    int n_run = 0;
    int n_fail = 0;
    bit done = 0;

    // reference model
    logic [XLEN-1:0] m_val [VE];
    bit              m_vld [VE];
    int              m_conf [CE];

    function automatic int vix(logic [PC_W-1:0] pc); return int'(pc[VW+1:2]); endfunction
    function automatic int cix(logic [PC_W-1:0] pc); return int'(pc[CW+1:2]); endfunction
    function automatic bit exp_use(logic [PC_W-1:0] pc);
        return m_vld[vix(pc)] && (m_conf[cix(pc)] >= 2);
    endfunction

    function automatic void m_reset();
        for (int i = 0; i < VE; i++) m_vld[i] = 0;
        for (int i = 0; i < CE; i++) m_conf[i] = 0;
    endfunction

    function automatic void m_train(logic [PC_W-1:0] pc, logic [XLEN-1:0] r);
        int v = vix(pc);
        int c = cix(pc);
        if (!m_vld[v]) begin
            m_vld[v] = 1; m_val[v] = r; m_conf[c] = 0;
        end else if (m_val[v] == r) begin
            if (m_conf[c] < 3) m_conf[c]++;
        end else begin
            if (m_conf[c] != 3) m_val[v] = r;
            if (m_conf[c] > 0) m_conf[c]--;
        end
    endfunction

    task automatic chk(string tag, logic [XLEN-1:0] act, logic [XLEN-1:0] exp);
        n_run++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %h expected %h", tag, act, exp);
        end
    endtask

    // one cycle: drive at negedge, check query against pre-edge model, then train model
    task automatic step(logic [PC_W-1:0] qp, logic en, logic [PC_W-1:0] tp,
                        logic [XLEN-1:0] r, string tag);
        @(negedge clk);
        q_pc = qp; t_en = en; t_pc = tp; t_result = r;
        #1;
        chk({tag, " use"}, XLEN'(q_use), XLEN'(exp_use(qp)));
        if (m_vld[vix(qp)]) chk({tag, " value"}, q_value, m_val[vix(qp)]);
        if (en) m_train(tp, r);
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst = 1'b1; t_en = 1'b0;
        repeat (2) @(negedge clk);
        rst = 1'b0;
        m_reset();
    endtask

    localparam logic [PC_W-1:0] PA = 16'h0100;  // value slot 0, counter 0
    localparam logic [PC_W-1:0] PB = 16'h0140;  // value slot 16, counter 0

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            n_fail++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
            $finish;
        end
    end

    initial begin
        void'($urandom(32'd2718));
        do_reset();
        // R1: nothing offered after reset
        for (int i = 0; i < 8; i++) step(PC_W'(i * 36), 1'b0, '0, '0, "R1 after reset");

        // R2: install, counter 0
        step(PA, 1'b1, PA, 64'h5, "R2 install same-cycle R8");
        step(PA, 1'b0, PA, 64'h0, "R2 installed");
        // R3/R7: matches climb; use appears at 2
        step(PA, 1'b1, PA, 64'h5, "R3 hit1");
        step(PA, 1'b1, PA, 64'h5, "R7 at1");
        step(PA, 1'b1, PA, 64'h5, "R7 at2");
        step(PA, 1'b1, PA, 64'h5, "R3 saturate");
        step(PA, 1'b0, PA, 64'h0, "R3 at3");
        // R10: disabled training ignored
        step(PA, 1'b0, PA, 64'h99, "R10 idle");
        step(PA, 1'b0, PA, 64'h0, "R10 unchanged");
        // R6: lock keeps value
        step(PA, 1'b1, PA, 64'h9, "R6 miss at3");
        step(PA, 1'b0, PA, 64'h0, "R6 kept");
        // R5: replace below lock
        step(PA, 1'b1, PA, 64'h9, "R5 miss at2");
        step(PA, 1'b0, PA, 64'h0, "R5 replaced");
        // R4: floor at 0
        step(PA, 1'b1, PA, 64'h7, "R4 miss at1");
        step(PA, 1'b1, PA, 64'h8, "R4 miss at0");
        step(PA, 1'b1, PA, 64'h8, "R4 hit from0");
        step(PA, 1'b1, PA, 64'h8, "R4 hit to2");
        step(PA, 1'b0, PA, 64'h0, "R4 floor");
        // R9: low bits ignored, shared counter
        step(PA | 16'h3, 1'b0, '0, '0, "R9 low bits");
        step(PB, 1'b1, PB, 64'hAB, "R9 alias install");
        step(PA, 1'b0, '0, '0, "R9 shared counter reset");
        step(PB, 1'b0, '0, '0, "R9 own value");

        // random mix
        for (int i = 0; i < 3000; i++) begin
            logic [PC_W-1:0] tp, qp;
            tp = PC_W'((($urandom % 24) << 2) | ($urandom & 3) | (($urandom & 1) << 12));
            qp = ($urandom & 1) ? tp : PC_W'((($urandom % 24) << 2) | ($urandom & 3));
            step(qp, ($urandom % 4) != 0, tp, XLEN'($urandom % 3) << 40, "R7 R8 random");
        end

        // R1 again after a mid-run reset
        do_reset();
        for (int i = 0; i < 24; i++) step(PC_W'(i << 2), 1'b0, '0, '0, "R1 re-reset");

        done = 1;
        $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end
endmodule